// File: doc/BRIEF.md
# One-Time Fuse Trim Register Bank

This block keeps the trim words that set a linear sensor's gain, its zero-field duty cycle and its output carrier. It also holds the calibration-enable bit and a lock that ends all trimming. Each of the four registers has two parts. One is a volatile addressed code that the programming sequencer raises one step at a time. The other is a set of one-time fuse bits that a blow strobe makes permanent. The word sent to the datapath is the bitwise OR of the two parts.

The sequencer chooses a register with `reg_sel` and then issues `inc` or `blow` strobes. A blow makes permanent only the single bit that the addressed code points at, so a code with several bits is built one bit per blow, with a power cycle between blows. `por` models that power cycle: it clears the volatile codes and leaves the fuses as they are. `rst` is a full reset that also clears the fuses, so a simulation can start from a fresh part. Once the lock fuse is blown, nothing in the bank can change again.

Top module: `trim_fuse_bank`

## Requirements
- R1: After `rst` every trim output, `cal_en`, `locked` and `blow_err` read 0.
- R2: Each `inc` strobe raises the addressed code of the register chosen by `reg_sel` by one. The encodings are 0 gain, 1 zero-field duty, 2 carrier/calibration, 3 lock. The code stops at its all-ones value. The new value appears on the outputs two clock edges after the strobe.
- R3: `por` sets every addressed code to 0. No code is ever lowered in any other way.
- R4: A `blow` whose addressed code has exactly one bit set sets that one fuse bit. No other fuse bit changes. The fuse stays set through `por`.
- R5: Fuses build up: blowing code 2 and then code 1 in a later power cycle gives 3, and the order of the two blows makes no difference.
- R6: A `blow` whose addressed code has zero bits set, or more than one, changes no fuse. It raises `blow_err` for one cycle, right after the strobe edge.
- R7: Each effective trim word is the bitwise OR of the fuse bits and the addressed code. It is not their sum.
- R8: In the 5-bit carrier/calibration register, bit 4 drives `cal_en` and bits 3:0 drive `freq_trim`. The gain and zero-field duty registers are 9 bits wide.
- R9: Blowing the lock register's addressed code 512 (bit 9) sets `locked`. Before that blow, reaching code 512 does not lock the bank.
- R10: While locked, `inc` and `blow` change no register and raise no error.
- R11: `locked` and all fuses stay through `por`. Only `rst` clears them.
- R12: If `inc` and `blow` come in the same cycle, the blow uses the current code and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset; clears codes and fuses |
| por | input | 1 | Power-cycle model; clears the volatile codes only |
| reg_sel | input | 2 | Register choice: 0 gain, 1 zero-field duty, 2 carrier/cal, 3 lock |
| inc | input | 1 | Raise the chosen register's addressed code by one |
| blow | input | 1 | Make the addressed single bit of the chosen register permanent |
| sens_trim | output | SENS_W | Effective gain trim word |
| qdc_trim | output | QDC_W | Effective zero-field duty trim word |
| freq_trim | output | FREQ_W | Effective carrier frequency trim |
| cal_en | output | 1 | Calibration-at-start enable |
| locked | output | 1 | Lock fuse is blown |
| blow_err | output | 1 | One-cycle flag for a rejected blow |

## Verification
Assertions check four things on every cycle. No fuse bit ever clears. A blow changes at most one fuse bit. A code only rises unless a power cycle comes before it. A rejected blow leaves the fuses alone, and a locked bank freezes both fuses and codes. The bench scenarios cover what a property cannot see alone. These are the OR-not-sum result, fuses building up over power cycles in either order, the bit split of the carrier/calibration word, saturation, the lock taking effect only on a blow, and the precedence of blow over increment.

// File: rtl/trim_fuse_pkg.sv
package trim_fuse_pkg;
  localparam int NSLOT = 4;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_SENS = 2'd0,
    SEL_QDC  = 2'd1,
    SEL_CAR  = 2'd2,
    SEL_LOCK = 2'd3
  } trim_sel_e;
endpackage

// File: rtl/trim_slot.sv
module trim_slot #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         por,
  input  logic         inc_i,
  input  logic         blow_i,
  input  logic         frozen_i,
  output logic [W-1:0] eff_o,
  output logic [W-1:0] fuse_o,
  output logic         err_o
);
  logic [W-1:0] code_q;
  logic [W-1:0] fuse_q;
  logic         single;
  logic         at_top;

  assign single = (code_q != '0) && ((code_q & (code_q - W'(1))) == '0);
  assign at_top = (code_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      fuse_q <= '0;
    end else if (por) begin
      code_q <= '0;
    end else if (!frozen_i) begin
      if (blow_i) begin
        if (single) fuse_q <= fuse_q | code_q;
      end else if (inc_i && !at_top) begin
        code_q <= code_q + W'(1);
      end
    end
  end

  assign err_o  = blow_i && !frozen_i && !por && !single;
  assign eff_o  = fuse_q | code_q;
  assign fuse_o = fuse_q;

  // R4
  fuse_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));
  // R4
  one_bit_blow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(fuse_q ^ $past(fuse_q)) <= 1));
  // R3
  code_rises_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(por)) |-> (code_q >= $past(code_q)));
  // R6
  bad_blow_chk: assert property (@(posedge clk) disable iff (rst)
    (blow_i && !frozen_i && !por && !$onehot(code_q)) |=> $stable(fuse_q));
  // R10
  frozen_fuse_chk: assert property (@(posedge clk) disable iff (rst)
    frozen_i |=> $stable(fuse_q));
  // R10
  frozen_code_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen_i && !por) |=> $stable(code_q));
endmodule

// File: rtl/trim_pipe.sv
module trim_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank
  import trim_fuse_pkg::*;
#(
  parameter int SENS_W = 9,
  parameter int QDC_W  = 9,
  parameter int FREQ_W = 4,
  parameter int LOCK_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              inc,
  input  logic              blow,
  output logic [SENS_W-1:0] sens_trim,
  output logic [QDC_W-1:0]  qdc_trim,
  output logic [FREQ_W-1:0] freq_trim,
  output logic              cal_en,
  output logic              locked
  ,output logic             blow_err
);
  localparam int CAR_W  = FREQ_W + 1;
  localparam int MAXA   = (SENS_W > QDC_W) ? SENS_W : QDC_W;
  localparam int MAXB   = (CAR_W > LOCK_W) ? CAR_W : LOCK_W;
  localparam int MAXW   = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int OUT_W  = SENS_W + QDC_W + CAR_W + 2;

  trim_sel_e                    sel_e;
  logic [NSLOT-1:0][MAXW-1:0]   eff_all;
  logic [NSLOT-1:0][MAXW-1:0]   fuse_all;
  logic [NSLOT-1:0]             err_all;
  logic                         frozen;
  logic [CAR_W-1:0]             car_eff;
  logic [OUT_W-1:0]             out_d;
  logic [OUT_W-1:0]             out_q;

  assign sel_e  = trim_sel_e'(reg_sel);
  assign frozen = fuse_all[SEL_LOCK][LOCK_W-1];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int W = (i == 0) ? SENS_W :
                       (i == 1) ? QDC_W  :
                       (i == 2) ? CAR_W  : LOCK_W;
    logic         hit;
    logic [W-1:0] eff;
    logic [W-1:0] fuse;
    assign hit = (sel_e == trim_sel_e'(SEL_W'(i)));
    trim_slot #(.W(W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .por      (por),
      .inc_i    (inc && hit),
      .blow_i   (blow && hit),
      .frozen_i (frozen),
      .eff_o    (eff),
      .fuse_o   (fuse),
      .err_o    (err_all[i])
    );
    assign eff_all[i]  = MAXW'(eff);
    assign fuse_all[i] = MAXW'(fuse);
  end

  assign car_eff = eff_all[SEL_CAR][CAR_W-1:0];
  assign out_d   = {(|err_all), frozen, car_eff,
                    eff_all[SEL_QDC][QDC_W-1:0], eff_all[SEL_SENS][SENS_W-1:0]};

  trim_pipe #(.W(OUT_W)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign sens_trim = out_q[SENS_W-1:0];
  assign qdc_trim  = out_q[SENS_W +: QDC_W];
  assign freq_trim = out_q[SENS_W+QDC_W +: FREQ_W];
  assign cal_en    = out_q[SENS_W+QDC_W+FREQ_W];
  assign locked    = out_q[OUT_W-2];
  assign blow_err  = out_q[OUT_W-1];

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  // R10
  locked_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen && !$past(rst)) |=> !blow_err);
endmodule

// File: tb/trim_fuse_bank_bench.sv
module trim_fuse_bank_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       inc = 1'b0;
  logic       blow = 1'b0;
  logic [8:0] sens_trim;
  logic [8:0] qdc_trim;
  logic [3:0] freq_trim;
  logic       cal_en;
  logic       locked;
  logic       blow_err;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  trim_fuse_bank u_trim_fuse_bank (
    .clk(clk), .rst(rst), .por(por), .reg_sel(reg_sel), .inc(inc), .blow(blow),
    .sens_trim(sens_trim), .qdc_trim(qdc_trim), .freq_trim(freq_trim),
    .cal_en(cal_en), .locked(locked), .blow_err(blow_err)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic full_reset();
    rst = 1'b1; settle(); settle(); rst = 1'b0; settle();
  endtask

  task automatic power_cycle();
    por = 1'b1; settle(); por = 1'b0; settle();
  endtask

  task automatic bump(logic [1:0] s, int n);
    reg_sel = s;
    for (int k = 0; k < n; k++) begin
      inc = 1'b1; settle(); inc = 1'b0;
    end
    settle();
  endtask

  task automatic fire(logic [1:0] s, output logic err);
    reg_sel = s; blow = 1'b1; settle(); blow = 1'b0;
    err = blow_err;
    settle();
  endtask

  task automatic t_reset();
    full_reset();
    chk("R1 sens", sens_trim, 0);
    chk("R1 qdc", qdc_trim, 0);
    chk("R1 freq", freq_trim, 0);
    chk("R1 cal", cal_en, 0);
    chk("R1 locked", locked, 0);
    chk("R1 err", blow_err, 0);
  endtask

  task automatic t_increment();
    full_reset();
    bump(2'd0, 5);
    chk("R2 sens after 5", sens_trim, 5);
    chk("R2 qdc untouched", qdc_trim, 0);
    bump(2'd1, 300);
    chk("R2 qdc after 300", qdc_trim, 300);
    bump(2'd2, 40);
    chk("R2 carrier saturates freq", freq_trim, 15);
    chk("R2 carrier saturates cal", cal_en, 1);
    power_cycle();
    chk("R3 por clears sens", sens_trim, 0);
    chk("R3 por clears qdc", qdc_trim, 0);
    chk("R3 por clears carrier", freq_trim, 0);
  endtask

  task automatic t_blow();
    logic e;
    full_reset();
    bump(2'd0, 4);
    fire(2'd0, e);
    chk("R4 single-bit blow no err", e, 0);
    power_cycle();
    chk("R4 fuse kept after por", sens_trim, 4);
    bump(2'd1, 2); fire(2'd1, e); power_cycle();
    bump(2'd1, 1); fire(2'd1, e); power_cycle();
    chk("R5 qdc 2 then 1", qdc_trim, 3);
    full_reset();
    bump(2'd1, 1); fire(2'd1, e); power_cycle();
    bump(2'd1, 2); fire(2'd1, e); power_cycle();
    chk("R5 qdc 1 then 2", qdc_trim, 3);
  endtask

  task automatic t_reject();
    logic e;
    full_reset();
    bump(2'd0, 3);
    fire(2'd0, e);
    chk("R6 multi-bit blow err", e, 1);
    chk("R6 err lasts one cycle", blow_err, 0);
    power_cycle();
    chk("R6 multi-bit no fuse", sens_trim, 0);
    fire(2'd0, e);
    chk("R6 zero-code blow err", e, 1);
    power_cycle();
    chk("R6 zero-code no fuse", sens_trim, 0);
  endtask

  task automatic t_or();
    logic e;
    full_reset();
    bump(2'd0, 4); fire(2'd0, e); power_cycle();
    bump(2'd0, 6);
    chk("R7 fuse4 or code6", sens_trim, 6);
    power_cycle();
    bump(2'd0, 3);
    chk("R7 fuse4 or code3", sens_trim, 7);
  endtask

  task automatic t_fields();
    logic e;
    full_reset();
    bump(2'd2, 17);
    chk("R8 cal bit4", cal_en, 1);
    chk("R8 freq bits", freq_trim, 1);
    fire(2'd2, e);
    chk("R8 two-bit carrier blow rejected", e, 1);
    power_cycle();
    bump(2'd2, 16); fire(2'd2, e); power_cycle();
    chk("R8 cal fuse", cal_en, 1);
    chk("R8 freq after cal fuse", freq_trim, 0);
    bump(2'd0, 511);
    chk("R8 sens 9-bit top", sens_trim, 511);
  endtask

  task automatic t_lock();
    logic e;
    full_reset();
    bump(2'd0, 2); fire(2'd0, e); power_cycle();
    bump(2'd3, 512);
    chk("R9 code 512 alone no lock", locked, 0);
    fire(2'd3, e);
    chk("R9 lock blow no err", e, 0);
    chk("R9 locked", locked, 1);
    bump(2'd0, 1);
    chk("R10 inc ignored", sens_trim, 2);
    fire(2'd0, e);
    chk("R10 blow no err when locked", e, 0);
    power_cycle();
    chk("R11 locked after por", locked, 1);
    chk("R11 fuse after por", sens_trim, 2);
    bump(2'd1, 1);
    chk("R10 qdc frozen", qdc_trim, 0);
    full_reset();
    chk("R11 rst clears lock", locked, 0);
    chk("R11 rst clears fuse", sens_trim, 0);
  endtask

  task automatic t_both();
    full_reset();
    bump(2'd1, 2);
    reg_sel = 2'd1; inc = 1'b1; blow = 1'b1; settle();
    inc = 1'b0; blow = 1'b0; settle();
    chk("R12 inc dropped", qdc_trim, 2);
    power_cycle();
    chk("R12 blow used current code", qdc_trim, 2);
  endtask

  initial begin
    t_reset();
    t_increment();
    t_blow();
    t_reject();
    t_or();
    t_fields();
    t_lock();
    t_both();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule